// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Flow Control and Break

This block is the transmit half of an asynchronous serial controller. Software loads a one-character transmit buffer and a set of control flags. The flags are a request-to-send enable, a break request, a buffer-empty interrupt enable, a character-length code and three bit-rate settings. When the line may be used, the block copies the buffer into a shift register. It then sends a frame: one low start bit, the data bits least significant first, and one high stop bit.

Sending is gated by a clear-to-send input and by the block's own request-to-send output. A break request turns the line into a continuous low level for as long as the request stays set. The bit time is the input clock divided by a 3 or 4 prescaler, by a further factor of 2 or 16, and by a programmable rate divisor. The host can read a buffer-empty flag and a shift-register-empty flag, and a maskable interrupt request follows the buffer-empty flag.

Top module: `async_tx`

## Requirements
- R1: While reset is asserted and just after it, txLine=1, rtsOut=0, brkActive=0, bufEmpty=1, shiftEmpty=1 and txIrq=0. All configuration fields reset to zero.
- R2: The buffer is copied into the shift register on the clock edge after one in which all of these hold: the buffer holds data, rtsOut=1, ctsIn=1, no break is requested and no character or break is in progress. On that edge bufEmpty becomes 1, shiftEmpty becomes 0 and txLine goes low for the start bit. If any condition is missing, nothing is sent.
- R3: A frame is one start bit (0), then N = 5 + cfgCharLen data bits sent least significant bit first, then one stop bit (1). cfgCharLen is 2 bits, giving 0→5 and 3→8. Buffer bits at position N and above are never sent.
- R4: Every bit, the start bit included, lasts exactly T = P·2·M·D clock cycles. P is 4 when cfgRefDiv4=1 and 3 otherwise. M is 8 when cfgDiv8=1 and 1 otherwise. D is cfgRate, where 0 counts as 1.
- R5: shiftEmpty returns to 1 on the edge that ends the stop bit. If the buffer was reloaded meanwhile, the next start bit begins one clock later.
- R6: rtsOut rises on the edge after cfgRtsReq=1 is latched. While no character is being sent and cfgRtsReq=0, it falls when ctsIn=0 or the buffer is empty. It stays high while a character is in the shift register.
- R7: While no character is in progress, a break request with ctsIn=1 and rtsOut=1 starts break mode on the next edge: brkActive=1 and txLine=0. Break mode lasts until the request is withdrawn, and the line then returns high. Without ctsIn=1, no break starts.
- R8: A break request has priority over buffered data. During break the buffer is not sent. It goes out only after break ends.
- R9: txIrq is 1 exactly when bufEmpty=1 and the latched interrupt enable is 1.
- R10: A buffer write clears bufEmpty on the following edge. When neither a frame nor a break is in progress, txLine stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWr | input | 1 | Latch all cfg* inputs this cycle |
| cfgRtsReq | input | 1 | Request-to-send enable |
| cfgBrkReq | input | 1 | Break request |
| cfgIntEn | input | 1 | Buffer-empty interrupt enable |
| cfgCharLen | input | 2 | Data bits minus 5 |
| cfgRefDiv4 | input | 1 | Prescale by 4 (1) or by 3 (0) |
| cfgDiv8 | input | 1 | Extra divide by 8 |
| cfgRate | input | RATE_W | Rate divisor; 0 acts as 1 |
| bufWr | input | 1 | Write bufData into the transmit buffer |
| bufData | input | DATA_W | Character to send |
| ctsIn | input | 1 | Clear-to-send, active high |
| txLine | output | 1 | Serial output, idles high |
| rtsOut | output | 1 | Request-to-send, active high |
| brkActive | output | 1 | Break mode in progress |
| bufEmpty | output | 1 | Transmit buffer empty |
| shiftEmpty | output | 1 | Shift register empty |
| txIrq | output | 1 | Buffer-empty interrupt request |

## Verification
Every cycle, the assertions check these properties:
- the line is low during break;
- break and transfers start only after clear-to-send and request-to-send were both high;
- each transfer starts with a low start bit;
- request-to-send holds while a character is shifting;
- the interrupt never fires with a loaded buffer;
- the line idles high.

Only the bench scenarios can show the rest. That covers the frame contents and their masking, the exact bit time over every prescale and divisor combination in a small sweep, the one-clock gap between back-to-back frames, and when the request-to-send output is released. The order of break and buffered data is also shown there.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP,
    ST_BREAK
  } txState_t;

  typedef enum logic [1:0] {
    LN_HOLD,
    LN_SPACE,
    LN_MARK,
    LN_DATA
  } lineSel_t;

  typedef struct packed {
    logic     load;
    lineSel_t lineSel;
  } txStrobe_t;

  typedef struct packed {
    logic       rtsReq;
    logic       brkReq;
    logic       intEn;
    logic [1:0] charLen;
    logic       refDiv4;
    logic       div8;
  } txCfg_t;

endpackage

// File: rtl/async_tx_baud.sv
module async_tx_baud #(
  parameter int RATE_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              restart,
  input  logic              run,
  input  logic              refDiv4,
  input  logic              div8,
  input  logic [RATE_W-1:0] rate,
  output logic              bitTick
);
  localparam int DIV_W = RATE_W + 4;

  logic [1:0]        preCnt;
  logic [1:0]        preLast;
  logic [DIV_W-1:0]  divCnt;
  logic [DIV_W-1:0]  divLast;
  logic [RATE_W-1:0] rateEff;
  logic              refTick;

  always_comb begin
    preLast = refDiv4 ? 2'd3 : 2'd2;
    rateEff = (rate == '0) ? RATE_W'(1) : rate;
    divLast = (DIV_W'(rateEff) << (div8 ? 4 : 1)) - DIV_W'(1);
    refTick = run && (preCnt == preLast);
    bitTick = refTick && (divCnt == divLast);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      divCnt <= '0;
    end else if (restart) begin
      preCnt <= '0;
      divCnt <= '0;
    end else if (run) begin
      if (refTick) begin
        preCnt <= '0;
        divCnt <= (divCnt == divLast) ? '0 : divCnt + DIV_W'(1);
      end else begin
        preCnt <= preCnt + 2'd1;
      end
    end
  end

endmodule

// File: rtl/async_tx_ctrl.sv
module async_tx_ctrl
  import async_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  txCfg_t    cfg,
  input  logic      ctsIn,
  input  logic      bufEmpty,
  input  logic      bitTick,
  output txStrobe_t strobe,
  output logic      baudRun,
  output logic      rtsOut,
  output logic      brkActive,
  output logic      shiftEmpty
);
  localparam int BIT_W    = $clog2(DATA_W);
  localparam int LEN_BASE = DATA_W - 3;

  txState_t         state, stateNxt;
  logic [BIT_W-1:0] bitCnt, bitCntNxt;
  logic [BIT_W-1:0] lastBit;
  logic             canBreak;
  logic             canXfer;
  logic             frameDone;

  always_comb begin
    lastBit  = BIT_W'(LEN_BASE - 1) + BIT_W'(cfg.charLen);
    canBreak = cfg.brkReq && ctsIn && rtsOut;
    canXfer  = !bufEmpty && ctsIn && rtsOut && !cfg.brkReq;
    stateNxt = state;
    bitCntNxt = bitCnt;
    strobe.load    = 1'b0;
    strobe.lineSel = LN_HOLD;
    frameDone = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (canBreak) begin
          stateNxt       = ST_BREAK;
          strobe.lineSel = LN_SPACE;
        end else if (canXfer) begin
          stateNxt       = ST_START;
          strobe.load    = 1'b1;
          strobe.lineSel = LN_SPACE;
        end
      end
      ST_START: begin
        if (bitTick) begin
          stateNxt       = ST_DATA;
          bitCntNxt      = '0;
          strobe.lineSel = LN_DATA;
        end
      end
      ST_DATA: begin
        if (bitTick) begin
          if (bitCnt == lastBit) begin
            stateNxt       = ST_STOP;
            strobe.lineSel = LN_MARK;
          end else begin
            bitCntNxt      = bitCnt + BIT_W'(1);
            strobe.lineSel = LN_DATA;
          end
        end
      end
      ST_STOP: begin
        if (bitTick) begin
          stateNxt  = ST_IDLE;
          frameDone = 1'b1;
        end
      end
      ST_BREAK: begin
        if (!cfg.brkReq) begin
          stateNxt       = ST_IDLE;
          strobe.lineSel = LN_MARK;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign baudRun   = (state == ST_START) || (state == ST_DATA) || (state == ST_STOP);
  assign brkActive = (state == ST_BREAK);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      bitCnt     <= '0;
      shiftEmpty <= 1'b1;
      rtsOut     <= 1'b0;
    end else begin
      state  <= stateNxt;
      bitCnt <= bitCntNxt;
      if (strobe.load) shiftEmpty <= 1'b0;
      else if (frameDone) shiftEmpty <= 1'b1;
      if (cfg.rtsReq) rtsOut <= 1'b1;
      else if (state == ST_IDLE && (!ctsIn || bufEmpty)) rtsOut <= 1'b0;
    end
  end

endmodule

// File: rtl/async_tx_dp.sv
module async_tx_dp
  import async_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strobe,
  input  logic [1:0]        charLen,
  input  logic              bufWr,
  input  logic [DATA_W-1:0] bufData,
  output logic              bufEmpty,
  output logic              txLine
);
  logic [DATA_W-1:0] bufReg;
  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] lenMask;

  assign lenMask = {DATA_W{1'b1}} >> (2'd3 - charLen);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufReg   <= '0;
      bufEmpty <= 1'b1;
      shiftReg <= '0;
      txLine   <= 1'b1;
    end else begin
      if (bufWr) begin
        bufReg   <= bufData;
        bufEmpty <= 1'b0;
      end else if (strobe.load) begin
        bufEmpty <= 1'b1;
      end
      if (strobe.load) shiftReg <= bufReg & lenMask;
      unique case (strobe.lineSel)
        LN_SPACE: txLine <= 1'b0;
        LN_MARK:  txLine <= 1'b1;
        LN_DATA: begin
          txLine   <= shiftReg[0];
          shiftReg <= shiftReg >> 1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/async_tx.sv
module async_tx
  import async_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int RATE_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWr,
  input  logic              cfgRtsReq,
  input  logic              cfgBrkReq,
  input  logic              cfgIntEn,
  input  logic [1:0]        cfgCharLen,
  input  logic              cfgRefDiv4,
  input  logic              cfgDiv8,
  input  logic [RATE_W-1:0] cfgRate,
  input  logic              bufWr,
  input  logic [DATA_W-1:0] bufData,
  input  logic              ctsIn,
  output logic              txLine,
  output logic              rtsOut,
  output logic              brkActive,
  output logic              bufEmpty,
  output logic              shiftEmpty,
  output logic              txIrq
);
  txCfg_t            cfg;
  logic [RATE_W-1:0] rateReg;
  txStrobe_t         strobe;
  logic              baudRun;
  logic              bitTick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg     <= '0;
      rateReg <= '0;
    end else if (cfgWr) begin
      cfg.rtsReq  <= cfgRtsReq;
      cfg.brkReq  <= cfgBrkReq;
      cfg.intEn   <= cfgIntEn;
      cfg.charLen <= cfgCharLen;
      cfg.refDiv4 <= cfgRefDiv4;
      cfg.div8    <= cfgDiv8;
      rateReg     <= cfgRate;
    end
  end

  async_tx_baud #(.RATE_W(RATE_W)) u_baud (
    .clk(clk), .rstN(rstN), .restart(strobe.load), .run(baudRun),
    .refDiv4(cfg.refDiv4), .div8(cfg.div8), .rate(rateReg), .bitTick(bitTick)
  );

  async_tx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfg(cfg), .ctsIn(ctsIn), .bufEmpty(bufEmpty),
    .bitTick(bitTick), .strobe(strobe), .baudRun(baudRun), .rtsOut(rtsOut),
    .brkActive(brkActive), .shiftEmpty(shiftEmpty)
  );

  async_tx_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .charLen(cfg.charLen),
    .bufWr(bufWr), .bufData(bufData), .bufEmpty(bufEmpty), .txLine(txLine)
  );

  assign txIrq = bufEmpty && cfg.intEn;

endmodule

// File: rtl/async_tx_chk.sv
module async_tx_chk (
  input logic clk,
  input logic rstN,
  input logic ctsIn,
  input logic txLine,
  input logic rtsOut,
  input logic brkActive,
  input logic bufEmpty,
  input logic shiftEmpty,
  input logic txIrq
);
  AST_BREAK_LINE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    brkActive |-> !txLine); // R7
  AST_BREAK_NEEDS_CTS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(brkActive) |-> ($past(ctsIn) && $past(rtsOut))); // R7
  AST_XFER_GATED: assert property (@(posedge clk) disable iff (!rstN)
    $fell(shiftEmpty) |-> ($past(ctsIn) && $past(rtsOut) && !$past(bufEmpty))); // R2
  AST_XFER_START_BIT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(shiftEmpty) |-> !txLine); // R2
  AST_RTS_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !shiftEmpty |-> rtsOut); // R6
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    txIrq |-> bufEmpty); // R9
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (shiftEmpty && !brkActive) |-> txLine); // R10
endmodule

bind async_tx async_tx_chk u_chk (
  .clk(clk), .rstN(rstN), .ctsIn(ctsIn), .txLine(txLine), .rtsOut(rtsOut),
  .brkActive(brkActive), .bufEmpty(bufEmpty), .shiftEmpty(shiftEmpty), .txIrq(txIrq)
);

// File: tb/sim_async_tx.sv
module sim_async_tx;
  localparam int DATA_W = 8;
  localparam int RATE_W = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWr = 1'b0;
  logic cRts = 1'b0, cBrk = 1'b0, cIe = 1'b0, cR4 = 1'b0, cD8 = 1'b0;
  logic [1:0] cCl = 2'd0;
  logic [RATE_W-1:0] cRate = '0;
  logic bufWr = 1'b0;
  logic [DATA_W-1:0] bufData = '0;
  logic ctsIn = 1'b0;
  logic txLine, rtsOut, brkActive, bufEmpty, shiftEmpty, txIrq;
  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  async_tx #(.DATA_W(DATA_W), .RATE_W(RATE_W)) u0 (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgRtsReq(cRts), .cfgBrkReq(cBrk),
    .cfgIntEn(cIe), .cfgCharLen(cCl), .cfgRefDiv4(cR4), .cfgDiv8(cD8),
    .cfgRate(cRate), .bufWr(bufWr), .bufData(bufData), .ctsIn(ctsIn),
    .txLine(txLine), .rtsOut(rtsOut), .brkActive(brkActive),
    .bufEmpty(bufEmpty), .shiftEmpty(shiftEmpty), .txIrq(txIrq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cfgPulse();
    cfgWr = 1'b1;
    @(negedge clk);
    cfgWr = 1'b0;
  endtask

  task automatic bufWrite(input logic [7:0] d);
    bufData = d;
    bufWr = 1'b1;
    @(negedge clk);
    bufWr = 1'b0;
  endtask

  task automatic waitStart(input string tag);
    int lat = 0;
    while (txLine !== 1'b0 && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    chk(tag, lat, 1);
  endtask

  task automatic sendFrame(input logic [7:0] d, input int cl, input int r4,
                           input int d8, input int rt);
    int t = (r4 != 0 ? 4 : 3) * 2 * (d8 != 0 ? 8 : 1) * rt;
    int n = 5 + cl;
    logic [7:0] got = '0;
    logic [7:0] mask = 8'hFF >> (3 - cl);
    cCl = 2'(cl); cR4 = 1'(r4); cD8 = 1'(d8); cRate = RATE_W'(rt);
    cfgPulse();
    bufWrite(d);
    waitStart("R2 start one edge after write");
    chk("R2 bufEmpty set on copy", int'(bufEmpty), 1);
    chk("R2 shiftEmpty cleared on copy", int'(shiftEmpty), 0);
    for (int k = 1; k <= t * (n + 2); k++) begin
      @(negedge clk);
      if (k == t - 1) chk("R4 start bit held to T", int'(txLine), 0);
      if (k == t) chk("R4 data starts at T", int'(txLine), 1);
      for (int i = 0; i < n; i++)
        if (k == t * (1 + i) + t / 2) got[i] = txLine;
      if (k == t * (n + 1) + t / 2) chk("R3 stop bit high", int'(txLine), 1);
      if (k == t * (n + 2) - 1) chk("R5 shiftEmpty before stop end", int'(shiftEmpty), 0);
      if (k == t * (n + 2)) chk("R5 shiftEmpty after stop end", int'(shiftEmpty), 1);
    end
    chk("R3 data bits LSB first masked", int'(got), int'(d & mask));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [7:0] pats [2] = '{8'hA5, 8'h5B};
    repeat (3) @(negedge clk);
    chk("R1 txLine in reset", int'(txLine), 1);
    chk("R1 bufEmpty in reset", int'(bufEmpty), 1);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 rtsOut", int'(rtsOut), 0);
    chk("R1 brkActive", int'(brkActive), 0);
    chk("R1 shiftEmpty", int'(shiftEmpty), 1);
    chk("R1 txIrq", int'(txIrq), 0);

    // gating: request-to-send off
    cIe = 1'b1; cCl = 2'd3; cRate = RATE_W'(1);
    cfgPulse();
    chk("R9 irq with empty buffer", int'(txIrq), 1);
    ctsIn = 1'b1;
    bufWrite(8'h81);
    chk("R10 write clears bufEmpty", int'(bufEmpty), 0);
    chk("R9 irq drops when loaded", int'(txIrq), 0);
    repeat (40) @(negedge clk);
    chk("R2 no send while rts off", int'(shiftEmpty), 1);
    chk("R10 idle line high", int'(txLine), 1);
    chk("R6 rts stays low", int'(rtsOut), 0);
    // gating: clear-to-send low
    ctsIn = 1'b0; cRts = 1'b1;
    cfgPulse();
    @(negedge clk);
    chk("R6 rts rises", int'(rtsOut), 1);
    repeat (40) @(negedge clk);
    chk("R2 no send while cts low", int'(shiftEmpty), 1);
    ctsIn = 1'b1;
    waitStart("R2 send starts after cts rises");
    repeat (6 * 10 + 4) @(negedge clk);
    chk("R5 frame complete", int'(shiftEmpty), 1);
    chk("R9 irq back", int'(txIrq), 1);

    // sweep of length, prescale, divide and divisor
    for (int cl = 0; cl < 4; cl++)
      for (int r4 = 0; r4 < 2; r4++)
        for (int d8 = 0; d8 < 2; d8++)
          for (int rt = 1; rt <= 2; rt++)
            for (int p = 0; p < 2; p++)
              sendFrame(pats[p], cl, r4, d8, rt);

    // back-to-back frames, T = 6, N = 8
    cCl = 2'd3; cR4 = 1'b0; cD8 = 1'b0; cRate = RATE_W'(1);
    cfgPulse();
    bufWrite(8'h3C);
    waitStart("R2 first of pair");
    bufWrite(8'hC3);
    chk("R10 reload during frame", int'(bufEmpty), 0);
    for (int k = 2; k <= 61; k++) begin
      @(negedge clk);
      if (k == 60) chk("R5 line high at stop end", int'(txLine), 1);
      if (k == 61) chk("R5 next start one clock later", int'(txLine), 0);
    end
    repeat (70) @(negedge clk);

    // rts release with empty buffer
    cRts = 1'b0;
    cfgPulse();
    @(negedge clk);
    chk("R6 rts falls with empty buffer", int'(rtsOut), 0);
    // rts held during a frame
    cRts = 1'b1;
    cfgPulse();
    @(negedge clk);
    bufWrite(8'h81);
    cRts = 1'b0;
    cfgPulse();
    repeat (20) @(negedge clk);
    chk("R6 rts held while shifting", int'(rtsOut), 1);
    repeat (60) @(negedge clk);
    chk("R6 rts falls after frame", int'(rtsOut), 0);
    chk("R5 frame done", int'(shiftEmpty), 1);
    // rts release with cts low and loaded buffer
    cRts = 1'b1;
    cfgPulse();
    @(negedge clk);
    ctsIn = 1'b0;
    bufWrite(8'h81);
    cRts = 1'b0;
    cfgPulse();
    @(negedge clk);
    chk("R6 rts falls with cts low", int'(rtsOut), 0);
    chk("R2 buffer kept", int'(bufEmpty), 0);
    cRts = 1'b1;
    cfgPulse();
    ctsIn = 1'b1;
    repeat (80) @(negedge clk);
    chk("R2 buffer sent later", int'(bufEmpty), 1);

    // break
    ctsIn = 1'b0; cBrk = 1'b1;
    cfgPulse();
    repeat (10) @(negedge clk);
    chk("R7 no break without cts", int'(brkActive), 0);
    chk("R7 line high without cts", int'(txLine), 1);
    ctsIn = 1'b1;
    @(negedge clk);
    chk("R7 break active", int'(brkActive), 1);
    chk("R7 break line low", int'(txLine), 0);
    bufWrite(8'h55);
    repeat (40) @(negedge clk);
    chk("R8 data held during break", int'(bufEmpty), 0);
    chk("R8 no shift during break", int'(shiftEmpty), 1);
    chk("R7 line still low", int'(txLine), 0);
    cBrk = 1'b0;
    cfgPulse();
    @(negedge clk);
    chk("R7 break ended", int'(brkActive), 0);
    chk("R7 line returns high", int'(txLine), 1);
    @(negedge clk);
    chk("R8 data sent after break", int'(txLine), 0);
    repeat (80) @(negedge clk);
    chk("R8 frame after break done", int'(shiftEmpty), 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule